// File: doc/BRIEF.md
# Per-Window Display Pixel Formatter

This block sits in the video output path, between the serialised plane data and the colour-lookup RAM. For every displayed pixel it takes the raw plane bits: 24 main-plane bits, 8 overlay bits, 2 pop-up bits and a 4-bit window tag. From these it builds colour-lookup indices. The tag selects one of 16 entries in a mode table. Each entry states whether the window holds RGB or colour-index data. It also gives the buffer half shown in double-buffered colour-index mode, the colour-index depth, and which 256-entry section of the colormap the result falls in.

Non-zero pop-up bits take precedence over everything else, and non-zero overlay bits take precedence over the main planes. Both have fixed colormap sections of their own. Pixels arrive at half the video rate, so the block contains two identical lanes, one for even pixels and one for odd pixels. The two lanes share one mode table. Software writes the mode table at any time through a shadow copy, and the copy becomes visible only at a frame boundary. Each lane has a fixed two-cycle latency, which keeps it aligned with the video timing.

Top module: `win_pixel_formatter`

## Requirements
- R1: After the synchronous active-low reset, every output index and every lane valid is 0. Every mode-table entry reads as 0, which means colour-index, single buffer, 12-bit depth, section 0.
- R2: When a lane's pop-up bits are non-zero, all three of its indices equal 31*256 + pop-up value, whatever the other planes and the mode are.
- R3: When the pop-up bits are zero and the overlay bits are non-zero, all three indices equal 30*256 + overlay value.
- R4: In colour-index mode without double buffering, all three indices equal (section*256 + main bits [11:0]) modulo 8192, and the buffer-select bit has no effect.
- R5: In double-buffered colour-index mode, buffer-select = 1 uses main bits [23:12] and buffer-select = 0 uses main bits [11:0], each with section*256 added.
- R6: With the narrow-depth bit set in colour-index mode, only the low 8 bits of the chosen 12-bit half are used.
- R7: In RGB mode the red, green and blue indices are section*256 plus main bits [23:16], [15:8] and [7:0] respectively. The double-buffer and buffer-select bits have no effect.
- R8: A mode entry is 9 bits: bit 8 RGB, bit 7 double buffer, bit 6 buffer select, bit 5 narrow depth, bits 4:0 section. A write lands in a shadow table. The lanes see it only after a frame-start pulse, and a write in the same cycle as that pulse is included.
- R9: Outputs and the lane valid appear exactly two clock cycles after the inputs, and back-to-back pixels stay in order.
- R10: The two lanes work independently on different pixels and tags in the same cycle, using the shared mode table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mode-table write strobe |
| cfg_addr | input | 4 | Mode-table entry to write |
| cfg_data | input | 9 | Mode entry value (layout in R8) |
| frame_start | input | 1 | Frame-boundary pulse; copies the shadow table to the active table |
| pix_vld | input | 1 | Pixel pair present on the plane inputs |
| pix_planes | input | 48 | Main-plane bits, lane n at [24n+23:24n] |
| ovl_planes | input | 16 | Overlay bits, lane n at [8n+7:8n] |
| pop_planes | input | 4 | Pop-up bits, lane n at [2n+1:2n] |
| win_tag | input | 8 | Window tag, lane n at [4n+3:4n] |
| out_vld | output | 2 | Per-lane output valid |
| out_idx_r | output | 26 | Red lookup index, lane n at [13n+12:13n] |
| out_idx_g | output | 26 | Green lookup index, same packing |
| out_idx_b | output | 26 | Blue lookup index, same packing |

## Verification
The bench puts the plane overrides in front of every mode, including overlay over an RGB window and pop-up over a non-zero overlay. A formatter with the priority reversed would show menus underneath overlay graphics. It also covers the section offset that wraps past the top of the index range, the buffer-select bit in a window that is not double-buffered, and the buffer-select bit in an RGB window. A design that got these wrong would read the wrong half or show an unintended colour. A mode written without a frame pulse must not change the result, because a design that applied it at once would tear mid-frame. A write made in the same cycle as the pulse must take effect with that pulse. Pixels are streamed back to back with different values on the two lanes, which exposes an off-by-one latency and lanes that share or swap state.

// File: rtl/pxfmt_pkg.sv
// Package: shared widths and record types of the pixel formatter.
// Assumes the colormap is split into sections of 2**SECT_SHIFT entries.
package pxfmt_pkg;
    parameter int PIX_W      = 24;   // main-plane bits per pixel
    parameter int OVL_W      = 8;    // overlay bits per pixel
    parameter int POP_W      = 2;    // pop-up bits per pixel
    parameter int SECT_W     = 5;    // colormap section number width
    parameter int NARROW_W   = 8;    // reduced colour-index depth
    parameter int SECT_SHIFT = 8;    // log2 of section size

    localparam int HALF_W = PIX_W / 2;   // colour-index half width
    localparam int COMP_W = PIX_W / 3;   // RGB component width

    // One window mode entry; bit order is the software-visible layout.
    typedef struct packed {
        logic              rgb;    // 1 = RGB, 0 = colour index
        logic              dbl;    // double-buffered colour index
        logic              back;   // buffer half select
        logic              d8;     // narrow colour-index depth
        logic [SECT_W-1:0] sect;   // colormap section number
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // Raw plane bits of one pixel.
    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [OVL_W-1:0] ovl;
        logic [POP_W-1:0] pop;
    } planes_t;
endpackage

// File: rtl/pxfmt_mode_table.sv
// Module: per-window mode table with shadow and active copies.
// Writes go to the shadow copy; the active copy, which the lanes read,
// is reloaded from the shadow (including a same-cycle write) on frame_start.
// Assumes one write per cycle; reads are combinational, one port per lane.
module pxfmt_mode_table
    import pxfmt_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [TAG_W-1:0]        wr_addr,
    input  mode_t                   wr_mode,
    input  logic                    frame_start,
    input  logic [LANES*TAG_W-1:0]  rd_tag,
    output mode_t [LANES-1:0]       rd_mode
);
    localparam int ENTRIES = 1 << TAG_W;

    mode_t [ENTRIES-1:0] shadow_q;
    mode_t [ENTRIES-1:0] shadow_d;
    mode_t [ENTRIES-1:0] active_q;

    // Shadow next state: apply this cycle's write.
    always_comb begin
        shadow_d = shadow_q;
        if (wr_en) begin
            shadow_d[wr_addr] = wr_mode;
        end
    end

    // Hold shadow; publish it to the active copy at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            shadow_q <= shadow_d;
            if (frame_start) begin
                active_q <= shadow_d;
            end
        end
    end

    // One read port per lane.
    for (genvar g = 0; g < LANES; g++) begin : gen_rd
        assign rd_mode[g] = active_q[rd_tag[g*TAG_W +: TAG_W]];
    end

    // R8: the table the lanes see only changes right after a frame pulse.
    a_r8_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> $stable(active_q));
endmodule

// File: rtl/pxfmt_lane_select.sv
// Module: combinational plane priority and index build for one pixel.
// Priority: pop-up (non-zero), then overlay (non-zero), then main planes
// interpreted by the window mode. Sums wrap at the index width.
module pxfmt_lane_select
    import pxfmt_pkg::*;
#(
    parameter int IDX_W    = 13,
    parameter int OVL_SECT = 30,
    parameter int POP_SECT = 31
) (
    input  planes_t           pl,
    input  mode_t             md,
    output logic [IDX_W-1:0]  idx_r,
    output logic [IDX_W-1:0]  idx_g,
    output logic [IDX_W-1:0]  idx_b
);
    localparam logic [IDX_W-1:0] POP_BASE = IDX_W'(POP_SECT * (1 << SECT_SHIFT));
    localparam logic [IDX_W-1:0] OVL_BASE = IDX_W'(OVL_SECT * (1 << SECT_SHIFT));
    localparam logic [HALF_W-1:0] NARROW_MASK = HALF_W'((1 << NARROW_W) - 1);

    logic [IDX_W-1:0]  sect_base;
    logic [HALF_W-1:0] ci_half;
    logic [HALF_W-1:0] ci_val;
    logic [IDX_W-1:0]  ci_idx;

    // Colour-index path: half select, depth mask, section offset.
    always_comb begin
        sect_base = IDX_W'(md.sect) << SECT_SHIFT;
        ci_half   = (md.dbl && md.back) ? pl.pix[PIX_W-1 -: HALF_W]
                                        : pl.pix[HALF_W-1:0];
        ci_val    = md.d8 ? (ci_half & NARROW_MASK) : ci_half;
        ci_idx    = sect_base + IDX_W'(ci_val);
    end

    // Source priority and final index per colour channel.
    always_comb begin
        if (pl.pop != '0) begin
            idx_r = POP_BASE + IDX_W'(pl.pop);
            idx_g = idx_r;
            idx_b = idx_r;
        end else if (pl.ovl != '0) begin
            idx_r = OVL_BASE + IDX_W'(pl.ovl);
            idx_g = idx_r;
            idx_b = idx_r;
        end else if (md.rgb) begin
            idx_r = sect_base + IDX_W'(pl.pix[PIX_W-1 -: COMP_W]);
            idx_g = sect_base + IDX_W'(pl.pix[COMP_W +: COMP_W]);
            idx_b = sect_base + IDX_W'(pl.pix[COMP_W-1:0]);
        end else begin
            idx_r = ci_idx;
            idx_g = ci_idx;
            idx_b = ci_idx;
        end
    end
endmodule

// File: rtl/pxfmt_lane.sv
// Module: one formatter lane, two register stages.
// Stage 1 captures planes and the looked-up mode; stage 2 registers the
// built indices. Assumes the mode arrives in the same cycle as its pixel.
module pxfmt_lane
    import pxfmt_pkg::*;
#(
    parameter int IDX_W    = 13,
    parameter int OVL_SECT = 30,
    parameter int POP_SECT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_in,
    input  planes_t           pl_in,
    input  mode_t             md_in,
    output logic              vld_out,
    output logic [IDX_W-1:0]  idx_r,
    output logic [IDX_W-1:0]  idx_g,
    output logic [IDX_W-1:0]  idx_b
);
    localparam logic [IDX_W-1:0] POP_BASE = IDX_W'(POP_SECT * (1 << SECT_SHIFT));
    localparam logic [IDX_W-1:0] OVL_BASE = IDX_W'(OVL_SECT * (1 << SECT_SHIFT));

    logic             vld_s1;
    planes_t          pl_s1;
    mode_t            md_s1;
    logic [IDX_W-1:0] sel_r, sel_g, sel_b;

    // Stage 1: capture pixel planes and their window mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s1 <= 1'b0;
            pl_s1  <= '0;
            md_s1  <= '0;
        end else begin
            vld_s1 <= vld_in;
            pl_s1  <= pl_in;
            md_s1  <= md_in;
        end
    end

    pxfmt_lane_select #(
        .IDX_W    (IDX_W),
        .OVL_SECT (OVL_SECT),
        .POP_SECT (POP_SECT)
    ) u_sel (
        .pl    (pl_s1),
        .md    (md_s1),
        .idx_r (sel_r),
        .idx_g (sel_g),
        .idx_b (sel_b)
    );

    // Stage 2: register the finished indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_out <= 1'b0;
            idx_r   <= '0;
            idx_g   <= '0;
            idx_b   <= '0;
        end else begin
            vld_out <= vld_s1;
            idx_r   <= sel_r;
            idx_g   <= sel_g;
            idx_b   <= sel_b;
        end
    end

    // Cycles since reset, saturating at the pipeline depth (checks only).
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R9: valid emerges two cycles after it entered.
    a_r9_two_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (vld_out == $past(vld_in, 2)));

    // R2: non-zero pop-up bits decide all three channels.
    a_r2_popup_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(pl_in.pop, 2) != '0) |->
        (idx_r == POP_BASE + IDX_W'($past(pl_in.pop, 2)) &&
         idx_g == idx_r && idx_b == idx_r));

    // R3: overlay decides when pop-up is clear.
    a_r3_overlay_next: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(pl_in.pop, 2) == '0 && $past(pl_in.ovl, 2) != '0) |->
        (idx_r == OVL_BASE + IDX_W'($past(pl_in.ovl, 2)) &&
         idx_g == idx_r && idx_b == idx_r));
endmodule

// File: rtl/win_pixel_formatter.sv
// Module: top of the per-window display pixel formatter.
// Holds one shared mode table and LANES identical lanes, each handling one
// pixel of the group delivered per clock. Lane n uses slice n of every bus.
module win_pixel_formatter
    import pxfmt_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int TAG_W    = 4,
    parameter int IDX_W    = 13,
    parameter int OVL_SECT = 30,
    parameter int POP_SECT = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [TAG_W-1:0]        cfg_addr,
    input  logic [MODE_W-1:0]       cfg_data,
    input  logic                    frame_start,
    input  logic                    pix_vld,
    input  logic [LANES*PIX_W-1:0]  pix_planes,
    input  logic [LANES*OVL_W-1:0]  ovl_planes,
    input  logic [LANES*POP_W-1:0]  pop_planes,
    input  logic [LANES*TAG_W-1:0]  win_tag,
    output logic [LANES-1:0]        out_vld,
    output logic [LANES*IDX_W-1:0]  out_idx_r,
    output logic [LANES*IDX_W-1:0]  out_idx_g,
    output logic [LANES*IDX_W-1:0]  out_idx_b
);
    mode_t [LANES-1:0] lane_mode;

    pxfmt_mode_table #(
        .TAG_W (TAG_W),
        .LANES (LANES)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_addr     (cfg_addr),
        .wr_mode     (mode_t'(cfg_data)),
        .frame_start (frame_start),
        .rd_tag      (win_tag),
        .rd_mode     (lane_mode)
    );

    // One lane per pixel position of the group.
    for (genvar g = 0; g < LANES; g++) begin : gen_lane
        planes_t lane_pl;

        // Gather this lane's plane slices into one record.
        always_comb begin
            lane_pl.pix = pix_planes[g*PIX_W +: PIX_W];
            lane_pl.ovl = ovl_planes[g*OVL_W +: OVL_W];
            lane_pl.pop = pop_planes[g*POP_W +: POP_W];
        end

        pxfmt_lane #(
            .IDX_W    (IDX_W),
            .OVL_SECT (OVL_SECT),
            .POP_SECT (POP_SECT)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_in  (pix_vld),
            .pl_in   (lane_pl),
            .md_in   (lane_mode[g]),
            .vld_out (out_vld[g]),
            .idx_r   (out_idx_r[g*IDX_W +: IDX_W]),
            .idx_g   (out_idx_g[g*IDX_W +: IDX_W]),
            .idx_b   (out_idx_b[g*IDX_W +: IDX_W])
        );
    end
endmodule

// File: tb/win_pixel_formatter_tb.sv
`timescale 1ns/1ps
module win_pixel_formatter_tb;
    typedef struct packed {
        logic [3:0]  tag;
        logic [23:0] pix;
        logic [7:0]  ovl;
        logic [1:0]  pop;
        logic [12:0] er;
        logic [12:0] eg;
        logic [12:0] eb;
    } vec_t;

    localparam int NV = 13;
    // Mode entries for tags 0..8: {rgb,dbl,back,d8,sect[4:0]}.
    localparam logic [8:0] MODES [9] = '{
        9'h000, 9'h002, 9'h0C1, 9'h081, 9'h104, 9'h023, 9'h01F, 9'h040, 9'h1C0 };
    localparam vec_t VEC [NV] = '{
        '{4'd0, 24'hABC123, 8'h00, 2'd0, 13'h0123, 13'h0123, 13'h0123},
        '{4'd1, 24'h000FFF, 8'h00, 2'd0, 13'h11FF, 13'h11FF, 13'h11FF},
        '{4'd2, 24'h5A6789, 8'h00, 2'd0, 13'h06A6, 13'h06A6, 13'h06A6},
        '{4'd3, 24'h5A6789, 8'h00, 2'd0, 13'h0889, 13'h0889, 13'h0889},
        '{4'd4, 24'h112233, 8'h00, 2'd0, 13'h0411, 13'h0422, 13'h0433},
        '{4'd5, 24'h000ABC, 8'h00, 2'd0, 13'h03BC, 13'h03BC, 13'h03BC},
        '{4'd6, 24'h000800, 8'h00, 2'd0, 13'h0700, 13'h0700, 13'h0700},
        '{4'd7, 24'hFED321, 8'h00, 2'd0, 13'h0321, 13'h0321, 13'h0321},
        '{4'd8, 24'hC0FFEE, 8'h00, 2'd0, 13'h00C0, 13'h00FF, 13'h00EE},
        '{4'd4, 24'h123456, 8'h5A, 2'd0, 13'h1E5A, 13'h1E5A, 13'h1E5A},
        '{4'd0, 24'h123456, 8'h80, 2'd2, 13'h1F02, 13'h1F02, 13'h1F02},
        '{4'd1, 24'h000000, 8'h00, 2'd0, 13'h0200, 13'h0200, 13'h0200},
        '{4'd2, 24'hFFFFFF, 8'hFF, 2'd1, 13'h1F01, 13'h1F01, 13'h1F01}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [8:0]  cfg_data = '0;
    logic        frame_start = 1'b0;
    logic        pix_vld = 1'b0;
    logic [47:0] pix_planes = '0;
    logic [15:0] ovl_planes = '0;
    logic [3:0]  pop_planes = '0;
    logic [7:0]  win_tag = '0;
    logic [1:0]  out_vld;
    logic [25:0] out_idx_r, out_idx_g, out_idx_b;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    win_pixel_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .frame_start(frame_start), .pix_vld(pix_vld),
        .pix_planes(pix_planes), .ovl_planes(ovl_planes), .pop_planes(pop_planes),
        .win_tag(win_tag), .out_vld(out_vld), .out_idx_r(out_idx_r),
        .out_idx_g(out_idx_g), .out_idx_b(out_idx_b)
    );

    function automatic string vec_req(int k);
        case (k)
            2, 3:    return "R5";
            4, 8:    return "R7";
            5:       return "R6";
            9:       return "R3";
            10, 12:  return "R2";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_lane(int lane, vec_t v);
        pix_planes[lane*24 +: 24] = v.pix;
        ovl_planes[lane*8 +: 8]   = v.ovl;
        pop_planes[lane*2 +: 2]   = v.pop;
        win_tag[lane*4 +: 4]      = v.tag;
    endtask

    task automatic check_lane(int lane, vec_t v, string req);
        chk(req, $sformatf("lane%0d red", lane),   32'(out_idx_r[lane*13 +: 13]), 32'(v.er));
        chk(req, $sformatf("lane%0d green", lane), 32'(out_idx_g[lane*13 +: 13]), 32'(v.eg));
        chk(req, $sformatf("lane%0d blue", lane),  32'(out_idx_b[lane*13 +: 13]), 32'(v.eb));
    endtask

    // Same stimulus on both lanes, wait out the two-stage latency, check.
    task automatic run_one(vec_t v, string req);
        @(negedge clk);
        drive_lane(0, v);
        drive_lane(1, v);
        @(negedge clk);
        @(negedge clk);
        check_lane(0, v, req);
        check_lane(1, v, req);
    endtask

    task automatic cfg_write(logic [3:0] a, logic [8:0] d, logic fs);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d; frame_start = fs;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs cleared by reset.
        chk("R1", "out_vld", 32'(out_vld), 32'd0);
        chk("R1", "red", 32'(out_idx_r), 32'd0);
        chk("R1", "green", 32'(out_idx_g), 32'd0);
        chk("R1", "blue", 32'(out_idx_b), 32'd0);
        // R1: table reads as zero mode (CI 12-bit, section 0).
        run_one('{4'd5, 24'h000ABC, 8'h00, 2'd0, 13'h0ABC, 13'h0ABC, 13'h0ABC}, "R1");

        // R8: writes without a frame pulse stay invisible.
        for (int k = 0; k < 9; k++) cfg_write(4'(k), MODES[k], 1'b0);
        run_one('{4'd4, 24'h112233, 8'h00, 2'd0, 13'h0233, 13'h0233, 13'h0233}, "R8");
        pulse_frame();
        run_one('{4'd4, 24'h112233, 8'h00, 2'd0, 13'h0411, 13'h0422, 13'h0433}, "R8");

        // Vector walk, streamed back to back; lane 1 offset by 5 vectors (R10).
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i == 1) chk("R9", "valid too early", 32'(out_vld), 32'd0);
            if (i >= 2) begin
                chk("R9", "out_vld", 32'(out_vld), 32'd3);
                check_lane(0, VEC[i-2], vec_req(i-2));
                check_lane(1, VEC[(i+3)%NV], {vec_req((i+3)%NV), "/R10"});
            end
            if (i < NV) begin
                pix_vld = 1'b1;
                drive_lane(0, VEC[i]);
                drive_lane(1, VEC[(i+5)%NV]);
            end else begin
                pix_vld = 1'b0;
            end
        end
        // R9: valid drops two cycles after the input valid did.
        @(negedge clk);
        chk("R9", "valid after stop", 32'(out_vld), 32'd0);

        // R8: write in the same cycle as the pulse is included.
        cfg_write(4'd9, 9'h101, 1'b1);
        run_one('{4'd9, 24'h010203, 8'h00, 2'd0, 13'h0101, 13'h0102, 13'h0103}, "R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule